// File: doc/BRIEF.md
# Write-Only Serial Current-Level Receiver

This block is a receive-only slave on a two-wire serial bus (I2C protocol, write direction only). It holds the 8-bit level code for a constant-current coil driver and a sleep flag. An external host writes a fixed three-byte frame. The first byte is the 7-bit device address plus a direction bit. The second byte carries the sleep flag and the upper six code bits. The third byte carries the two low code bits. The block acknowledges each accepted byte by pulling the data line low. It loads the new code and flag together, and only once the whole frame has arrived.

Both bus lines are sampled by a system clock that runs well above the bus clock. Each line passes through a flop synchronizer and an edge detector. A frame state machine has four states:
- `ST_IDLE`: waiting for a start condition.
- `ST_RECV`: shifting in the eight bits of a byte.
- `ST_ACK`: driving the acknowledge bit.
- `ST_SKIP`: ignoring the bus after a foreign address, a read request or a complete frame.

The transitions are:
- Any state moves to `ST_RECV` on a start or repeated start.
- Any state moves to `ST_IDLE` on a stop.
- `ST_RECV` moves to `ST_ACK` at the falling clock edge that ends the eighth bit of an accepted byte.
- `ST_RECV` moves to `ST_SKIP` at that same edge when the address byte is rejected.
- `ST_ACK` moves back to `ST_RECV` at the falling edge that ends the ninth clock.
- `ST_ACK` moves to `ST_SKIP` at that edge after the final byte.

An active-low power-down pin resets the whole block asynchronously. A fault input forces the drive-enable output off.

Top module: `csi_current_slave`

## Requirements
- R1: While `pwr_n` is low, `level_code` is 0x00, `sleep_flag` is 0, `drive_en` is 0 and `sda_pull` is 0. Any partly received frame is lost, and after release a fresh frame is accepted normally.
- R2: A first byte equal to {7'b0110011, 1'b0} (address sent MSB first, then a 0 direction bit) is acknowledged.
- R3: If the first byte carries any other address, or the direction bit is 1, no acknowledge is given. No later byte is acknowledged and the outputs keep their values until the next start condition.
- R4: The acknowledge (`sda_pull` = 1) rises while SCL is low after the eighth falling clock edge of a byte. It falls after the ninth falling edge, so it is never asserted while SCL is high during a data bit.
- R5: After a complete frame, `sleep_flag` equals bit 7 of the second byte. `level_code` equals {second byte bits 5..0, third byte bits 7..6}, in straight binary. Bit 6 of the second byte and bits 5..0 of the third byte have no effect.
- R6: The code and flag change together, and only when the third byte is acknowledged. A stop or repeated start before that point discards the partial frame. A repeated start begins a new frame.
- R7: Bytes that follow the third byte of a frame are not acknowledged and do not change the outputs.
- R8: `drive_en` is 0 one clock after `fault_in` is 1 or `sleep_flag` is 1. It is 1 otherwise, once `pwr_n` is high. `fault_in` does not alter `level_code` or `sleep_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 16 times the bus clock |
| pwr_n | input | 1 | Active-low power-down and asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| fault_in | input | 1 | External fault; forces drive enable off |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| level_code | output | 8 | Current level code, 0x00 zero to 0xFF full scale |
| sleep_flag | output | 1 | Power-down flag from the last complete frame |
| drive_en | output | 1 | Output stage enable |

## Verification
A wrong internal state shows up at the ports in one of two ways. It may appear at the very next acknowledge slot, as a missing or extra `sda_pull` pulse while the master samples during SCL high. Or it may appear after the stop, as a `level_code` or `sleep_flag` that does not match the frame. A wrong bit counter or byte index moves the acknowledge slot or the bit split of the code. Both are exposed within one frame by sweeping code values whose low and high fields vary independently. A state machine that fails to enter or leave the ignore state is exposed by the acknowledge bits of a foreign-address frame, a read frame, a truncated frame and a fourth byte.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int BYTE_BITS   = 8;
    localparam int FRAME_BYTES = 3;
    localparam int CNT_W       = $clog2(BYTE_BITS + 1);
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } csi_state_e;
endpackage

// File: rtl/csi_line_sync.sv
module csi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rose,
    output logic fell
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= line_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rose  = level & ~prev;
    assign fell  = ~level & prev;
endmodule

// File: rtl/csi_frame_fsm.sv
module csi_frame_fsm
    import csi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0110011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       scl_rose,
    input  logic       scl_fell,
    input  logic       sda_lvl,
    output logic       sda_pull,
    output logic       commit,
    output logic [7:0] frame_code,
    output logic       frame_pd
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    csi_state_e       state, nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       shreg;
    logic             hold_pd;
    logic [5:0]       hold_hi;
    logic             addr_ok;

    assign addr_ok = (shreg == {DEV_ADDR, 1'b0});

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_evt) begin
            nxt = ST_RECV;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_RECV: begin
                    if (scl_fell && bit_cnt == FULL_CNT) begin
                        if (byte_idx == '0 && !addr_ok) nxt = ST_SKIP;
                        else                            nxt = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fell) begin
                        if (byte_idx == LAST_IDX) nxt = ST_SKIP;
                        else                      nxt = ST_RECV;
                    end
                end
                ST_SKIP: nxt = ST_SKIP;
            endcase
        end
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            hold_pd  <= 1'b0;
            hold_hi  <= '0;
        end else begin
            state <= nxt;
            if (start_evt) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
            end else if (state == ST_RECV && scl_rose && bit_cnt != FULL_CNT) begin
                shreg   <= {shreg[6:0], sda_lvl};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (state == ST_ACK && scl_fell) begin
                bit_cnt  <= '0;
                byte_idx <= byte_idx + 1'b1;
                if (byte_idx == IDX_W'(1)) begin
                    hold_pd <= shreg[7];
                    hold_hi <= shreg[5:0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull   = (state == ST_ACK);
        commit     = (state == ST_ACK) && scl_fell && !start_evt && !stop_evt
                     && (byte_idx == LAST_IDX);
        frame_code = {hold_hi, shreg[7:6]};
        frame_pd   = hold_pd;
    end

    // R2: the address slot is only acknowledged for the device address with write direction
    assert_addr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && byte_idx == '0) |-> (shreg == {DEV_ADDR, 1'b0}));

    // R3 and R7: the ignore state never leads to an acknowledge without a new start
    assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !start_evt) |=> (state != ST_ACK));
endmodule

// File: rtl/csi_hold_regs.sv
module csi_hold_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic [7:0] new_code,
    input  logic       new_pd,
    input  logic       fault_in,
    output logic [7:0] code,
    output logic       pd,
    output logic       drive_en
);
    logic pd_next;

    assign pd_next = commit ? new_pd : pd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code     <= '0;
            pd       <= 1'b0;
            drive_en <= 1'b0;
        end else begin
            if (commit) begin
                code <= new_code;
                pd   <= new_pd;
            end
            drive_en <= ~fault_in & ~pd_next;
        end
    end

    // R8: a fault switches the drive off on the next clock
    assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> !drive_en);
endmodule

// File: rtl/csi_current_slave.sv
module csi_current_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b0110011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       pwr_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       fault_in,
    output logic       sda_pull,
    output logic [7:0] level_code,
    output logic       sleep_flag,
    output logic       drive_en
);
    logic       scl_lvl, scl_rose, scl_fell;
    logic       sda_lvl, sda_rose, sda_fell;
    logic       start_evt, stop_evt;
    logic       commit;
    logic [7:0] frame_code;
    logic       frame_pd;

    csi_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(pwr_n), .line_in(scl_in),
        .level(scl_lvl), .rose(scl_rose), .fell(scl_fell)
    );

    csi_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(pwr_n), .line_in(sda_in),
        .level(sda_lvl), .rose(sda_rose), .fell(sda_fell)
    );

    // bus conditions: data edge while the clock stays high
    assign start_evt = scl_lvl & ~scl_rose & sda_fell;
    assign stop_evt  = scl_lvl & ~scl_rose & sda_rose;

    csi_frame_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(pwr_n),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rose(scl_rose), .scl_fell(scl_fell), .sda_lvl(sda_lvl),
        .sda_pull(sda_pull), .commit(commit),
        .frame_code(frame_code), .frame_pd(frame_pd)
    );

    csi_hold_regs u_hold (
        .clk(clk), .rst_n(pwr_n), .commit(commit),
        .new_code(frame_code), .new_pd(frame_pd), .fault_in(fault_in),
        .code(level_code), .pd(sleep_flag), .drive_en(drive_en)
    );

    // R4: acknowledge starts and ends while the bus clock is low
    assert_ack_rise_low_R4: assert property (@(posedge clk) disable iff (!pwr_n)
        $rose(sda_pull) |-> !scl_lvl);
    assert_ack_fall_low_R4: assert property (@(posedge clk) disable iff (!pwr_n)
        $fell(sda_pull) |-> !scl_lvl);

    // R6: the visible code and flag only move on a frame commit
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!pwr_n)
        !commit |=> ($stable(level_code) && $stable(sleep_flag)));
endmodule

// File: tb/tb_csi_current_slave.sv
module tb_csi_current_slave;
    localparam int Q = 6;
    localparam logic [7:0] WR_ADDR = {7'b0110011, 1'b0};

    logic       clk = 1'b0;
    logic       pwr_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       fault_in = 1'b0;
    logic       sda_pull;
    logic [7:0] level_code;
    logic       sleep_flag;
    logic       drive_en;
    logic       sda_bus;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_drv & ~sda_pull;

    csi_current_slave dut (
        .clk(clk), .pwr_n(pwr_n), .scl_in(scl_drv), .sda_in(sda_bus),
        .fault_in(fault_in), .sda_pull(sda_pull), .level_code(level_code),
        .sleep_flag(sleep_flag), .drive_en(drive_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(Q);
            scl_drv = 1'b1; tick(Q);
            chk("R4 no pull during data bit", sda_pull, 0);
            tick(Q);
            scl_drv = 1'b0;
        end
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        acked = sda_pull;
        tick(Q);
        scl_drv = 1'b0;
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] b2, input logic [7:0] b3,
                         output logic k0, output logic k1, output logic k2);
        bus_start;
        put_byte(a, k0);
        put_byte(b2, k1);
        put_byte(b3, k2);
        bus_stop;
        tick(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic k0, k1, k2, kx;
        logic [7:0] b2, b3;

        // R1 reset state
        tick(5);
        chk("R1 code in reset", level_code, 8'h00);
        chk("R1 flag in reset", sleep_flag, 0);
        chk("R1 pull in reset", sda_pull, 0);
        chk("R8 drive off in reset", drive_en, 0);
        pwr_n = 1'b1; tick(3);
        chk("R8 drive on after reset", drive_en, 1);

        // R2 R4 R5 sweep of codes, don't-care bits varied
        for (int c = 0; c < 256; c += 3) begin
            b2 = {1'b0, c[0] ^ c[3], c[7:2]};
            b3 = {c[1:0], ~c[7:2]};
            frame(WR_ADDR, b2, b3, k0, k1, k2);
            chk("R2 address ack", k0, 1);
            chk("R4 data ack 2", k1, 1);
            chk("R4 data ack 3", k2, 1);
            chk("R5 code", level_code, c[7:0]);
            chk("R5 flag", sleep_flag, 0);
        end
        frame(WR_ADDR, {2'b01, 6'h3F}, 8'hFF, k0, k1, k2);
        chk("R5 full scale", level_code, 8'hFF);

        // R5 R8 sleep flag
        frame(WR_ADDR, {2'b10, 6'h29}, 8'h40, k0, k1, k2);
        chk("R5 code with flag", level_code, 8'hA5);
        chk("R5 flag set", sleep_flag, 1);
        chk("R8 drive off by flag", drive_en, 0);
        frame(WR_ADDR, {2'b00, 6'h16}, 8'h80, k0, k1, k2);
        chk("R5 code 5A", level_code, 8'h5A);
        chk("R8 drive back on", drive_en, 1);

        // R8 fault
        fault_in = 1'b1; tick(2);
        chk("R8 fault drive off", drive_en, 0);
        chk("R8 fault keeps code", level_code, 8'h5A);
        chk("R8 fault keeps flag", sleep_flag, 0);
        fault_in = 1'b0; tick(2);
        chk("R8 fault released", drive_en, 1);

        // R3 wrong address
        frame({7'b0110100, 1'b0}, 8'h3F, 8'hC0, k0, k1, k2);
        chk("R3 foreign addr no ack", k0, 0);
        chk("R3 foreign data no ack", k1, 0);
        chk("R3 foreign data no ack 3", k2, 0);
        chk("R3 foreign keeps code", level_code, 8'h5A);

        // R3 read direction
        frame({7'b0110011, 1'b1}, 8'hBF, 8'hC0, k0, k1, k2);
        chk("R3 read no ack", k0, 0);
        chk("R3 read no data ack", k1, 0);
        chk("R3 read keeps code", level_code, 8'h5A);
        chk("R3 read keeps flag", sleep_flag, 0);

        // R6 partial frame then stop
        bus_start;
        put_byte(WR_ADDR, k0);
        put_byte(8'hBF, k1);
        bus_stop; tick(4);
        chk("R6 partial ack", k1, 1);
        chk("R6 partial keeps code", level_code, 8'h5A);
        chk("R6 partial keeps flag", sleep_flag, 0);

        // R6 partial then repeated start then full frame
        bus_start;
        put_byte(WR_ADDR, k0);
        put_byte(8'hBF, k1);
        bus_start;
        chk("R6 restart keeps code", level_code, 8'h5A);
        put_byte(WR_ADDR, k0);
        put_byte(8'h0F, k1);
        put_byte(8'h00, k2);
        bus_stop; tick(4);
        chk("R6 restart addr ack", k0, 1);
        chk("R6 restart new code", level_code, 8'h3C);
        chk("R6 restart flag", sleep_flag, 0);

        // R7 extra byte
        bus_start;
        put_byte(WR_ADDR, k0);
        put_byte(8'h20, k1);
        put_byte(8'h40, k2);
        put_byte(8'hFF, kx);
        chk("R7 extra no ack", kx, 0);
        put_byte(8'h00, kx);
        bus_stop; tick(4);
        chk("R7 extra no ack 2", kx, 0);
        chk("R7 code from frame", level_code, 8'h81);

        // R1 power-down mid-frame
        bus_start;
        put_byte(WR_ADDR, k0);
        pwr_n = 1'b0; tick(3);
        chk("R1 pd clears code", level_code, 8'h00);
        chk("R1 pd clears pull", sda_pull, 0);
        scl_drv = 1'b1; sda_drv = 1'b1; tick(2);
        pwr_n = 1'b1; tick(3);
        frame(WR_ADDR, {2'b00, 6'h1D}, 8'hC0, k0, k1, k2);
        chk("R1 fresh frame ack", k0, 1);
        chk("R1 fresh frame code", level_code, 8'h77);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule